// File: doc/BRIEF.md
# Peripheral Stop and CPU Sleep Controller

This block decides which on-chip peripherals receive a run enable and whether the CPU is halted. Software programs a stop-request register that holds one bit per peripheral: a 1 asks for that peripheral to be stopped and a 0 asks for it to run. The request does not reach the peripherals at once. It is copied into the applied stop state only when the bus-cycle-end strobe pulses, so a peripheral never starts or stops in the middle of a transfer. Stopping peripherals never halts the CPU.

Register accesses aimed at peripherals pass through an access gate. If the addressed peripheral is currently stopped, a write is dropped and a read returns zero. The access still completes normally, so the bus sees no error. One peripheral slot belongs to the serial unit. That unit does not keep its state while stopped, so the block holds a clear signal on it for as long as it is stopped.

A sleep strobe halts the CPU when standby is not selected, and the peripherals keep running. When standby is selected, this block ignores the sleep strobe. A wake strobe from outside releases the halt.

Top module: `pwr_gate_ctrl`

## Requirements
- R1: After synchronous reset the stop-request value and the applied stop state are both 0xFFF8: bits 0, 1 and 2 are 0, because those slots hold the DMA engine, the transfer controller and the RAM. `run_en` therefore reads 0x0007, `cpu_halt` is 0 and `ser_reset` is 1.
- R2: When `reg_wr` is high, `reg_wdata` appears on `reg_rdata` after the next clock edge. `run_en` does not change because of the write alone.
- R3: A clock edge with `bus_end` high sets `run_en` to the bitwise inverse of the stop-request value held before that edge. On an edge with `bus_end` low, `run_en` holds its value.
- R4: If `reg_wr` and `bus_end` arrive in the same cycle, the `bus_end` edge applies the old request value. The newly written value takes effect at the next `bus_end`.
- R5: `ser_reset` is 1 exactly while the serial slot (bit 5) is in the applied stop state, and 0 while that slot runs.
- R6: An access (`acc_req`) to a running slot is forwarded. One cycle later, `acc_rdata` carries the `mod_rdata` value sampled at the request, and `mod_wr` is 1 if `acc_we` was 1.
- R7: An access to a stopped slot is blocked. One cycle later, `acc_rdata` is 0 and `mod_wr` is 0.
- R8: Every access raises `acc_done` for exactly the following cycle, whether it was blocked or not.
- R9: A `sleep_req` with `standby_sel` at 0 sets `cpu_halt` on the next cycle and leaves `run_en` unchanged.
- R10: A `sleep_req` with `standby_sel` at 1 has no effect: `cpu_halt` stays 0.
- R11: `wake` clears `cpu_halt` on the next cycle. If `wake` and `sleep_req` arrive in the same cycle, `wake` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the stop-request register |
| reg_wdata | input | 16 | Stop-request write data, 1 = stop |
| reg_rdata | output | 16 | Current stop-request value |
| bus_end | input | 1 | End-of-bus-cycle strobe that applies the request |
| run_en | output | 16 | Per-slot run enable, 1 = running |
| ser_reset | output | 1 | Clear for the serial unit while it is stopped |
| acc_req | input | 1 | Peripheral register access request |
| acc_we | input | 1 | Access is a write |
| acc_sel | input | 4 | Slot index of the access |
| mod_rdata | input | 16 | Read data from the selected slot |
| mod_wr | output | 1 | Forwarded write enable |
| acc_rdata | output | 16 | Read data returned to the bus (0 when blocked) |
| acc_done | output | 1 | Access completion |
| sleep_req | input | 1 | Sleep instruction strobe |
| standby_sel | input | 1 | Standby selected; sleep ignored here when 1 |
| wake | input | 1 | External wake strobe |
| cpu_halt | output | 1 | CPU halt |

## Verification
Two pairs of events can fall in the same cycle. The first is a stop-register write together with `bus_end`. The bench drives both in one cycle and checks that `run_en` still follows the previous request, then checks that the next `bus_end` alone applies the new request. The second is `sleep_req` together with `wake`. The bench raises both in one cycle and expects `cpu_halt` to be 0. As a related check, an access is issued to a slot in the same window in which that slot was just stopped, to confirm that the gate uses the applied state and not the pending request.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int unsigned DEF_SLOTS = 16;
  localparam int unsigned DEF_DW    = 16;

  typedef enum logic [1:0] {
    HALT_IDLE  = 2'b00,
    HALT_ENTER = 2'b01,
    HALT_CLEAR = 2'b10
  } halt_cmd_e;

  function automatic halt_cmd_e decode_halt(input logic slp, input logic stby, input logic wk);
    if (wk)              return HALT_CLEAR;
    else if (slp && !stby) return HALT_ENTER;
    else                 return HALT_IDLE;
  endfunction
endpackage

// File: rtl/stop_bank.sv
module stop_bank #(
  parameter int unsigned SLOTS   = 16,
  parameter int unsigned DMA_IDX = 0,
  parameter int unsigned XFR_IDX = 1,
  parameter int unsigned RAM_IDX = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SLOTS-1:0] wdata,
  input  logic             apply,
  output logic [SLOTS-1:0] req_q,
  output logic [SLOTS-1:0] stop_q
);
  logic [SLOTS-1:0] boot_mask;

  for (genvar g = 0; g < SLOTS; g++) begin : g_mask
    assign boot_mask[g] = !((g == DMA_IDX) || (g == XFR_IDX) || (g == RAM_IDX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= boot_mask;
      stop_q <= boot_mask;
    end else begin
      if (wr)    req_q  <= wdata;
      if (apply) stop_q <= req_q;
    end
  end
endmodule

// File: rtl/access_gate.sv
module access_gate #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned DW    = 16,
  localparam int unsigned SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] stop_q,
  input  logic             req,
  input  logic             we,
  input  logic [SW-1:0]    sel,
  input  logic [DW-1:0]    rdata_in,
  output logic             wr_out,
  output logic [DW-1:0]    rdata_out,
  output logic             done
);
  logic allowed;
  assign allowed = req && !stop_q[sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_out    <= 1'b0;
      rdata_out <= '0;
      done      <= 1'b0;
    end else begin
      wr_out    <= allowed && we;
      rdata_out <= (allowed && !we) ? rdata_in : '0;
      done      <= req;
    end
  end
endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
  import pwr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic standby_sel,
  input  logic wake,
  output logic halt
);
  halt_cmd_e cmd;
  assign cmd = decode_halt(sleep_req, standby_sel, wake);

  always_ff @(posedge clk) begin
    if (rst) begin
      halt <= 1'b0;
    end else begin
      unique case (cmd)
        HALT_ENTER: halt <= 1'b1;
        HALT_CLEAR: halt <= 1'b0;
        default:    halt <= halt;
      endcase
    end
  end
endmodule

// File: rtl/pwr_gate_ctrl.sv
module pwr_gate_ctrl #(
  parameter int unsigned SLOTS   = pwr_pkg::DEF_SLOTS,
  parameter int unsigned DW      = pwr_pkg::DEF_DW,
  parameter int unsigned DMA_IDX = 0,
  parameter int unsigned XFR_IDX = 1,
  parameter int unsigned RAM_IDX = 2,
  parameter int unsigned SER_IDX = 5,
  localparam int unsigned SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [SLOTS-1:0] reg_wdata,
  output logic [SLOTS-1:0] reg_rdata,
  input  logic             bus_end,
  output logic [SLOTS-1:0] run_en,
  output logic             ser_reset,
  input  logic             acc_req,
  input  logic             acc_we,
  input  logic [SW-1:0]    acc_sel,
  input  logic [DW-1:0]    mod_rdata,
  output logic             mod_wr,
  output logic [DW-1:0]    acc_rdata,
  output logic             acc_done,
  input  logic             sleep_req,
  input  logic             standby_sel,
  input  logic             wake,
  output logic             cpu_halt
);
  logic [SLOTS-1:0] req_q;
  logic [SLOTS-1:0] stop_q;

  stop_bank #(
    .SLOTS(SLOTS), .DMA_IDX(DMA_IDX), .XFR_IDX(XFR_IDX), .RAM_IDX(RAM_IDX)
  ) u_bank (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .apply(bus_end), .req_q(req_q), .stop_q(stop_q)
  );

  access_gate #(.SLOTS(SLOTS), .DW(DW)) u_gate (
    .clk(clk), .rst(rst), .stop_q(stop_q), .req(acc_req), .we(acc_we),
    .sel(acc_sel), .rdata_in(mod_rdata), .wr_out(mod_wr),
    .rdata_out(acc_rdata), .done(acc_done)
  );

  sleep_ctl u_sleep (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .standby_sel(standby_sel),
    .wake(wake), .halt(cpu_halt)
  );

  assign reg_rdata = req_q;
  assign run_en    = ~stop_q;
  assign ser_reset = stop_q[SER_IDX];
endmodule

// File: rtl/pwr_gate_ctrl_chk.sv
module pwr_gate_ctrl_chk #(
  parameter int unsigned SLOTS   = 16,
  parameter int unsigned DW      = 16,
  parameter int unsigned SER_IDX = 5,
  localparam int unsigned SW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_end,
  input logic [SLOTS-1:0] reg_rdata,
  input logic [SLOTS-1:0] run_en,
  input logic             ser_reset,
  input logic             acc_req,
  input logic             acc_we,
  input logic [SW-1:0]    acc_sel,
  input logic             mod_wr,
  input logic [DW-1:0]    acc_rdata,
  input logic             acc_done,
  input logic             sleep_req,
  input logic             standby_sel,
  input logic             wake,
  input logic             cpu_halt
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!bus_end && !rst) |=> $stable(run_en));

  assert_apply_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_end && !rst) |=> (run_en == ~$past(reg_rdata)));

  assert_ser_clear_R5: assert property (@(posedge clk) disable iff (rst)
    ser_reset == !run_en[SER_IDX]);

  assert_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !rst && !run_en[acc_sel]) |=> (!mod_wr && acc_rdata == '0));

  assert_done_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !rst) |=> acc_done);

  assert_enter_R9: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && !standby_sel && !wake && !rst) |=> cpu_halt);

  assert_standby_R10: assert property (@(posedge clk) disable iff (rst)
    (sleep_req && standby_sel && !cpu_halt && !rst) |=> !cpu_halt);

  assert_wake_R11: assert property (@(posedge clk) disable iff (rst)
    (wake && !rst) |=> !cpu_halt);
endmodule

bind pwr_gate_ctrl pwr_gate_ctrl_chk #(.SLOTS(SLOTS), .DW(DW), .SER_IDX(SER_IDX)) u_chk (
  .clk(clk), .rst(rst), .bus_end(bus_end), .reg_rdata(reg_rdata), .run_en(run_en),
  .ser_reset(ser_reset), .acc_req(acc_req), .acc_we(acc_we), .acc_sel(acc_sel),
  .mod_wr(mod_wr), .acc_rdata(acc_rdata), .acc_done(acc_done),
  .sleep_req(sleep_req), .standby_sel(standby_sel), .wake(wake), .cpu_halt(cpu_halt)
);

// File: tb/tb_pwr_gate_ctrl.sv
module tb_pwr_gate_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        bus_end;
  logic [15:0] run_en;
  logic        ser_reset;
  logic        acc_req, acc_we;
  logic [3:0]  acc_sel;
  logic [15:0] mod_rdata;
  logic        mod_wr;
  logic [15:0] acc_rdata;
  logic        acc_done;
  logic        sleep_req, standby_sel, wake, cpu_halt;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwr_gate_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_end(bus_end), .run_en(run_en), .ser_reset(ser_reset),
    .acc_req(acc_req), .acc_we(acc_we), .acc_sel(acc_sel), .mod_rdata(mod_rdata),
    .mod_wr(mod_wr), .acc_rdata(acc_rdata), .acc_done(acc_done),
    .sleep_req(sleep_req), .standby_sel(standby_sel), .wake(wake), .cpu_halt(cpu_halt)
  );

  // vector: {wr, wdata[15:0], bus_end, expected run_en[15:0]}
  localparam int NV = 7;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 16'h0F00, 1'b0, 16'h0007},  // R2: write alone, no change
    {1'b0, 16'h0000, 1'b1, 16'hF0FF},  // R3: apply
    {1'b1, 16'hFFFF, 1'b1, 16'hF0FF},  // R4: same cycle, old value applied
    {1'b0, 16'h0000, 1'b0, 16'hF0FF},  // R3: hold
    {1'b0, 16'h0000, 1'b1, 16'h0000},  // R4: new value at next apply
    {1'b1, 16'h0000, 1'b1, 16'h0000},  // R4: same cycle again
    {1'b0, 16'h0000, 1'b1, 16'hFFFF}   // R3: all running
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_wr = 0; reg_wdata = '0; bus_end = 0; acc_req = 0; acc_we = 0;
    acc_sel = '0; sleep_req = 0; wake = 0;
  endtask

  task automatic access(input logic w, input logic [3:0] s);
    @(negedge clk);
    acc_req = 1; acc_we = w; acc_sel = s;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    standby_sel = 0;
    mod_rdata = 16'hABCD;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 req", reg_rdata, 16'hFFF8);
    chk("R1 run", run_en, 16'h0007);
    chk("R1 halt", {15'd0, cpu_halt}, 16'd0);
    chk("R1 ser", {15'd0, ser_reset}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reg_wr = VEC[i][33]; reg_wdata = VEC[i][32:17]; bus_end = VEC[i][16];
      @(negedge clk);
      chk("R3/R4 run_en", run_en, VEC[i][15:0]);
      if (VEC[i][33]) chk("R2 readback", reg_rdata, VEC[i][32:17]);
      idle();
    end

    // R5: serial slot running now, then stopped
    chk("R5 ser running", {15'd0, ser_reset}, 16'd0);
    @(negedge clk); reg_wr = 1; reg_wdata = 16'h0020;
    @(negedge clk); idle(); bus_end = 1;
    @(negedge clk); idle();
    chk("R5 ser stopped", {15'd0, ser_reset}, 16'd1);
    chk("R3 run slot5 off", run_en, 16'hFFDF);

    // R6 forwarded read and write on running slot 3
    access(1'b0, 4'd3);
    chk("R6 read data", acc_rdata, 16'hABCD);
    chk("R8 done read", {15'd0, acc_done}, 16'd1);
    access(1'b1, 4'd3);
    chk("R6 write fwd", {15'd0, mod_wr}, 16'd1);
    // R7 blocked on stopped slot 5
    access(1'b0, 4'd5);
    chk("R7 blocked read", acc_rdata, 16'h0000);
    chk("R8 done blocked", {15'd0, acc_done}, 16'd1);
    access(1'b1, 4'd5);
    chk("R7 blocked write", {15'd0, mod_wr}, 16'd0);
    @(negedge clk);
    chk("R8 done one cycle", {15'd0, acc_done}, 16'd0);

    // R7: pending stop on slot 3 not yet applied -> still forwarded
    @(negedge clk); reg_wr = 1; reg_wdata = 16'h0028;
    @(negedge clk); idle();
    access(1'b0, 4'd3);
    chk("R7 pending not applied", acc_rdata, 16'hABCD);

    // R10 standby selected: ignored
    standby_sel = 1;
    @(negedge clk); sleep_req = 1;
    @(negedge clk); idle();
    chk("R10 standby ignore", {15'd0, cpu_halt}, 16'd0);
    standby_sel = 0;
    // R9 sleep
    @(negedge clk); sleep_req = 1;
    @(negedge clk); idle();
    chk("R9 halt", {15'd0, cpu_halt}, 16'd1);
    chk("R9 run unchanged", run_en, 16'hFFDF);
    // R11 wake
    @(negedge clk); wake = 1;
    @(negedge clk); idle();
    chk("R11 wake", {15'd0, cpu_halt}, 16'd0);
    // R11 simultaneous
    @(negedge clk); sleep_req = 1; wake = 1;
    @(negedge clk); idle();
    chk("R11 wake wins", {15'd0, cpu_halt}, 16'd0);

    // R1 reset again mid-run
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 re-reset run", run_en, 16'h0007);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule